// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block produces the time-multiplexed level selection for a segment LCD with four common lines and thirty-two segment lines. A one-cycle `tick` strobe, taken from a divided oscillator, steps the scan. Each tick moves to the next half of a common phase. The two halves of a phase drive opposite polarities, so the average voltage across every pixel is zero. For every common and segment pin the block emits a 2-bit code, and the analog output stage uses that code to pick one of four supply rails. Code 0 is VSS, 1 is V2, 2 is V1 and 3 is VLCD.

Software sets three things through a one-cycle configuration write: the number of scanned commons (four or three), the bias (one third or one half), and how many of the top segment pins act as static general-purpose outputs. The display pattern arrives on a flat bit vector. An active-low inhibit input blanks the whole panel.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset, four commons are scanned at one-third bias, no pin is a port, and the scan sits at phase 0 in positive polarity. With inhibit high, this gives comLvl = 8'h57: COM0 at code 3 and the other commons at code 1.
- R2: Each cycle with tick high flips the polarity half. Every second tick advances the phase. The phase wraps to 0 after phase 3 (four commons) or after phase 2 (three commons). Without tick, the scan state holds.
- R3: At one-third bias the scanned common of the current phase drives code 3 in the positive half and code 0 in the negative half. Every other common drives code 1 in the positive half and code 2 in the negative half.
- R4: At one-third bias an LCD segment s reads bit dispBits[phase*32+s]. A set bit drives code 0 in the positive half and code 3 in the negative half. A clear bit drives code 2 in the positive half and code 1 in the negative half.
- R5: At one-half bias every level that is not a rail uses the single mid code 2, for unselected commons and for clear segments in both halves.
- R6: With three commons scanned, COM3 never selects and always drives the unselected level.
- R7: A written common count takes effect only when the scan wraps to phase 0. A write in the same cycle as the wrap takes effect at that wrap.
- R8: A written bias and port assignment reach the outputs in the cycle after the write.
- R9: Port select value n = 1..4 turns the top n segment pins (indices 31 down to 32-n) into ports. Values 0, 5, 6 and 7 select no ports. Port k drives segment 28+k with code 3 when portVal[k] is 1 and code 0 when it is 0, in both halves.
- R10: While inhibitN is low, every common, segment and port pin drives code 0. This blanking is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-phase advance strobe from the divided oscillator |
| inhibitN | input | 1 | Active-low display blank |
| cfgValid | input | 1 | Configuration write strobe |
| cfgDuty3 | input | 1 | 1 = scan three commons, 0 = scan four |
| cfgBiasHalf | input | 1 | 1 = one-half bias, 0 = one-third bias |
| cfgPortSel | input | 3 | Number of top segment pins used as ports |
| dispBits | input | 128 | Pixel bits, index phase*32+segment |
| portVal | input | 4 | Static values for ports 0..3 |
| comLvl | output | 8 | Level codes, common c at bits 2c+1:2c |
| segLvl | output | 64 | Level codes, segment s at bits 2s+1:2s |

## Verification
The hardest case to reach is a common-count write that lands exactly on the wrap tick, where the new value must bypass the pending register. A random write has only a small chance of hitting that cycle. A directed sequence therefore steps the scan to the last negative half and writes the new count on the wrapping tick. A long seeded random run then mixes sparse writes, ticks, blanking and pattern changes against a bench model of the scan.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int COM_N  = 4;
  localparam int SEG_N  = 32;
  localparam int PORT_N = 4;
  localparam int PH_W   = $clog2(COM_N);

  typedef enum logic [1:0] {
    LVL_VSS  = 2'd0,
    LVL_V2   = 2'd1,
    LVL_V1   = 2'd2,
    LVL_VLCD = 2'd3
  } lvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [PH_W-1:0]   phase;
    logic              pol;
    logic              duty3;
    logic              biasHalf;
    logic [PORT_N-1:0] portMask;
  } strobe_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int NCOM  = COM_N,
  parameter int NPORT = PORT_N
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       cfgValid,
  input  logic       cfgDuty3,
  input  logic       cfgBiasHalf,
  input  logic [2:0] cfgPortSel,
  output strobe_t    stb
);
  localparam int PW = $clog2(NCOM);

  logic [PW-1:0]    phase;
  logic             half;
  logic             duty3Act;
  logic             duty3Pend;
  logic             biasHalf;
  logic [NPORT-1:0] portMask;
  logic [NPORT-1:0] maskNext;
  logic [PW-1:0]    lastPhase;
  logic             wrap;

  always_comb begin
    int n;
    n = int'(cfgPortSel);
    if (n > NPORT) n = 0;
    for (int p = 0; p < NPORT; p++) maskNext[p] = (p >= NPORT - n);
  end

  assign lastPhase = duty3Act ? PW'(NCOM - 2) : PW'(NCOM - 1);
  assign wrap      = tick && half && (phase == lastPhase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      half      <= 1'b0;
      duty3Act  <= 1'b0;
      duty3Pend <= 1'b0;
      biasHalf  <= 1'b0;
      portMask  <= '0;
    end else begin
      if (cfgValid) begin
        duty3Pend <= cfgDuty3;
        biasHalf  <= cfgBiasHalf;
        portMask  <= maskNext;
      end
      if (tick) begin
        half <= ~half;
        if (half) phase <= wrap ? '0 : phase + 1'b1;
      end
      if (wrap) duty3Act <= cfgValid ? cfgDuty3 : duty3Pend;
    end
  end

  always_comb begin
    stb          = '0;
    stb.phase    = phase;
    stb.pol      = half;
    stb.duty3    = duty3Act;
    stb.biasHalf = biasHalf;
    stb.portMask = portMask;
  end
endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_drv_pkg::*;
#(
  parameter int NCOM  = COM_N,
  parameter int NSEG  = SEG_N,
  parameter int NPORT = PORT_N
) (
  input  strobe_t              stb,
  input  logic                 inhibitN,
  input  logic [NCOM*NSEG-1:0] dispBits,
  input  logic [NPORT-1:0]     portVal,
  output logic [2*NCOM-1:0]    comLvl,
  output logic [2*NSEG-1:0]    segLvl
);
  localparam int FIRST_PORT = NSEG - NPORT;

  lvl_e selLvl, idleLvl, onLvl, offLvl;
  logic [NSEG-1:0] dispRow;
  int scanned;

  always_comb begin
    scanned = stb.duty3 ? NCOM - 1 : NCOM;
    selLvl  = stb.pol ? LVL_VSS : LVL_VLCD;
    onLvl   = stb.pol ? LVL_VLCD : LVL_VSS;
    idleLvl = stb.biasHalf ? LVL_V1 : (stb.pol ? LVL_V1 : LVL_V2);
    offLvl  = stb.biasHalf ? LVL_V1 : (stb.pol ? LVL_V2 : LVL_V1);
    dispRow = dispBits[int'(stb.phase)*NSEG +: NSEG];
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    always_comb begin
      if (!inhibitN)
        comLvl[2*c +: 2] = LVL_VSS;
      else if ((int'(stb.phase) == c) && (c < scanned))
        comLvl[2*c +: 2] = selLvl;
      else
        comLvl[2*c +: 2] = idleLvl;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s >= FIRST_PORT) begin : g_port
      always_comb begin
        if (!inhibitN)
          segLvl[2*s +: 2] = LVL_VSS;
        else if (stb.portMask[s-FIRST_PORT])
          segLvl[2*s +: 2] = portVal[s-FIRST_PORT] ? LVL_VLCD : LVL_VSS;
        else
          segLvl[2*s +: 2] = dispRow[s] ? onLvl : offLvl;
      end
    end else begin : g_lcd
      always_comb begin
        if (!inhibitN)
          segLvl[2*s +: 2] = LVL_VSS;
        else
          segLvl[2*s +: 2] = dispRow[s] ? onLvl : offLvl;
      end
    end
  end
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_drv_pkg::*;
#(
  parameter int NCOM  = COM_N,
  parameter int NSEG  = SEG_N,
  parameter int NPORT = PORT_N
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 inhibitN,
  input  logic                 cfgValid,
  input  logic                 cfgDuty3,
  input  logic                 cfgBiasHalf,
  input  logic [2:0]           cfgPortSel,
  input  logic [NCOM*NSEG-1:0] dispBits,
  input  logic [NPORT-1:0]     portVal,
  output logic [2*NCOM-1:0]    comLvl,
  output logic [2*NSEG-1:0]    segLvl
);
  strobe_t stb;

  lcd_seq_ctrl #(.NCOM(NCOM), .NPORT(NPORT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgValid(cfgValid),
    .cfgDuty3(cfgDuty3), .cfgBiasHalf(cfgBiasHalf),
    .cfgPortSel(cfgPortSel), .stb(stb)
  );

  lcd_seq_dp #(.NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT)) u_dp (
    .stb(stb), .inhibitN(inhibitN), .dispBits(dispBits),
    .portVal(portVal), .comLvl(comLvl), .segLvl(segLvl)
  );
endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
  import lcd_drv_pkg::*;
#(
  parameter int NCOM  = COM_N,
  parameter int NSEG  = SEG_N,
  parameter int NPORT = PORT_N
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              inhibitN,
  input strobe_t           stb,
  input logic [2*NCOM-1:0] comLvl,
  input logic [2*NSEG-1:0] segLvl
);
  int lastPh;
  logic [NCOM-1:0]  selFlags;
  logic [NPORT-1:0] railOk;

  always_comb begin
    lastPh = stb.duty3 ? NCOM - 2 : NCOM - 1;
    for (int c = 0; c < NCOM; c++)
      selFlags[c] = comLvl[2*c +: 2] == (stb.pol ? 2'd0 : 2'd3);
    for (int p = 0; p < NPORT; p++)
      railOk[p] = !stb.portMask[p] ||
                  segLvl[2*(NSEG-NPORT+p) +: 2] == 2'd0 ||
                  segLvl[2*(NSEG-NPORT+p) +: 2] == 2'd3;
  end

  AST_DARK_WHEN_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    !inhibitN |-> (comLvl == '0 && segLvl == '0)); // R10
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(stb.phase) && $stable(stb.pol))); // R2
  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(stb.phase) <= lastPh); // R2
  AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !(tick && stb.pol && int'(stb.phase) == lastPh) |=> $stable(stb.duty3)); // R7
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    inhibitN |-> $countones(selFlags) == 1); // R3
  AST_PORT_RAIL: assert property (@(posedge clk) disable iff (!rstN)
    inhibitN |-> &railOk); // R9
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .inhibitN(inhibitN),
  .stb(stb), .comLvl(comLvl), .segLvl(segLvl)
);

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;
  logic         clk = 1'b0;
  logic         rstN, tick, inhibitN, cfgValid, cfgDuty3, cfgBiasHalf;
  logic [2:0]   cfgPortSel;
  logic [127:0] dispBits;
  logic [3:0]   portVal;
  logic [7:0]   comLvl;
  logic [63:0]  segLvl;

  int nTests = 0, nFail = 0;
  int mPhase;
  bit mHalf, mDuty3, mPend, mBias;
  bit [3:0] mMask;

  always #2 clk = ~clk;

  lcd_mux_drive dut (
    .clk(clk), .rstN(rstN), .tick(tick), .inhibitN(inhibitN),
    .cfgValid(cfgValid), .cfgDuty3(cfgDuty3), .cfgBiasHalf(cfgBiasHalf),
    .cfgPortSel(cfgPortSel), .dispBits(dispBits), .portVal(portVal),
    .comLvl(comLvl), .segLvl(segLvl)
  );

  function automatic bit [3:0] decode(input bit [2:0] sel);
    case (sel)
      3'd1: return 4'b1000;
      3'd2: return 4'b1100;
      3'd3: return 4'b1110;
      3'd4: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic bit [1:0] expCom(input int c);
    int scanned = mDuty3 ? 3 : 4;
    if (!inhibitN) return 2'd0;
    if (c == mPhase && c < scanned) return mHalf ? 2'd0 : 2'd3;
    if (mBias) return 2'd2;
    return mHalf ? 2'd2 : 2'd1;
  endfunction

  function automatic bit [1:0] expSeg(input int s);
    if (!inhibitN) return 2'd0;
    if (s >= 28 && mMask[s-28]) return portVal[s-28] ? 2'd3 : 2'd0;
    if (dispBits[mPhase*32+s]) return mHalf ? 2'd3 : 2'd0;
    if (mBias) return 2'd2;
    return mHalf ? 2'd1 : 2'd2;
  endfunction

  task automatic check(input string tag);
    bit [7:0]  ec;
    bit [63:0] es;
    for (int c = 0; c < 4; c++) ec[2*c +: 2] = expCom(c);
    for (int s = 0; s < 32; s++) es[2*s +: 2] = expSeg(s);
    nTests++;
    if (comLvl !== ec || segLvl !== es) begin
      nFail++;
      $display("FAIL %s com=%h exp=%h seg=%h exp=%h", tag, comLvl, ec, segLvl, es);
    end
  endtask

  task automatic stepModel();
    bit oldPend = mPend;
    int last = mDuty3 ? 2 : 3;
    if (cfgValid) begin
      mPend = cfgDuty3; mBias = cfgBiasHalf; mMask = decode(cfgPortSel);
    end
    if (tick) begin
      if (!mHalf) mHalf = 1;
      else begin
        mHalf = 0;
        if (mPhase == last) begin
          mPhase = 0;
          mDuty3 = cfgValid ? cfgDuty3 : oldPend;
        end else mPhase++;
      end
    end
  endtask

  // inputs are set at the falling edge before calling
  task automatic runCycle(input string tag);
    #1 check(tag);
    @(posedge clk);
    stepModel();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    tick = 0; cfgValid = 0; cfgDuty3 = 0; cfgBiasHalf = 0; cfgPortSel = 0;
  endtask

  function automatic string pickTag();
    if (!inhibitN) return "R10";
    if (mMask != 0) return "R9";
    if (mBias) return "R5";
    if (mDuty3) return "R6";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CD5EED));
    rstN = 0; inhibitN = 1; portVal = 4'hF;
    dispBits = {$urandom(), $urandom(), $urandom(), $urandom()};
    idleInputs();
    mPhase = 0; mHalf = 0; mDuty3 = 0; mPend = 0; mBias = 0; mMask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    nTests++;
    if (comLvl !== 8'h57) begin
      nFail++;
      $display("FAIL R1 com=%h exp=57", comLvl);
    end
    check("R1");
    @(negedge clk);

    // R2: hold without tick, then walk a full frame
    runCycle("R2");
    runCycle("R2");
    for (int i = 0; i < 10; i++) begin
      tick = 1; runCycle("R2");
      tick = 0; runCycle("R3");
    end

    // R7: duty write mid frame is deferred
    cfgValid = 1; cfgDuty3 = 1; runCycle("R7");
    cfgValid = 0;
    for (int i = 0; i < 12; i++) begin tick = 1; runCycle("R7"); end
    tick = 0;
    // R7: write exactly on the wrapping tick
    while (!(mHalf && mPhase == (mDuty3 ? 2 : 3))) begin tick = 1; runCycle("R7"); end
    tick = 1; cfgValid = 1; cfgDuty3 = 0; runCycle("R7");
    tick = 0; cfgValid = 0;
    for (int i = 0; i < 10; i++) begin tick = 1; runCycle("R7"); end
    tick = 0;

    // R8: bias and ports act next cycle
    cfgValid = 1; cfgBiasHalf = 1; cfgPortSel = 3'd2; runCycle("R8");
    cfgValid = 0; runCycle("R8");
    runCycle("R5");
    cfgValid = 1; cfgBiasHalf = 0; cfgPortSel = 3'd6; runCycle("R8");
    cfgValid = 0; runCycle("R9");

    // R10: blanking
    inhibitN = 0; runCycle("R10");
    inhibitN = 1; runCycle("R10");

    for (int i = 0; i < 4000; i++) begin
      tick        = ($urandom() % 3) == 0;
      inhibitN    = ($urandom() % 10) != 0;
      cfgValid    = ($urandom() % 40) == 0;
      cfgDuty3    = 1'($urandom() % 2);
      cfgBiasHalf = 1'($urandom() % 2);
      cfgPortSel  = 3'($urandom() % 8);
      portVal     = 4'($urandom() % 16);
      if (($urandom() % 16) == 0)
        dispBits = {$urandom(), $urandom(), $urandom(), $urandom()};
      runCycle(pickTag());
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule